// File: doc/BRIEF.md
# Shared-RAM Message Queue Index Controller

This block keeps the bookkeeping for a bank of independent circular message queues that all sit in one shared message RAM. Each queue is set up on its own as either an outgoing (transmit) or incoming (receive) queue, with its own base address and a depth counted in fixed-size message slots. The block moves no data. It holds a write index, a read index and an occupancy count for every queue, and turns the right index into a RAM byte address.

Two parties use each queue. The host writes outgoing messages and reads incoming ones. The protocol engine does the reverse. Each side selects a queue, reads back the address it should touch next together with the fill flags, and after it has finished with that slot it pulses an increment. In a transmit queue the host is the producer. In a receive queue the protocol engine is the producer. Increments that would overrun a full queue, or drain an empty one, are dropped and recorded in sticky flags that the host can see.

Top module: `msg_fifo_ctrl`

## Requirements
- R1: After reset every queue is a receive queue with base 0 and a depth of one slot, and it is empty. Both sides report address 0, empty=1, full=0, not-empty=0, and both sticky flags are 0.
- R2: A configuration write to queue N loads its direction (1 = transmit), its base address and its depth. The depth is encoded as slots minus one, in 5 bits, so depths run from 1 to 32. The write also clears the queue's write index, read index, count and sticky flags. In that cycle the configuration write overrides any increment aimed at the same queue.
- R3: In a transmit queue, a host increment advances the write index. The host address is base + write_index*16, the controller address is base + read_index*16, and a controller increment advances the read index.
- R4: In a receive queue, a controller increment advances the write index. The controller address is base + write_index*16, the host address is base + read_index*16, and a host increment advances the read index.
- R5: An index that advances from depth-1 returns to 0. Addresses are taken modulo 2048 bytes.
- R6: Full means count equals depth. Empty means count is zero. Not-empty is the inverse of empty.
- R7: A producer increment on a full queue changes no index or count and sets that queue's overflow sticky flag. The flag stays set until the next configuration write to that queue.
- R8: A consumer increment on an empty queue changes no index or count and sets that queue's underflow sticky flag. The flag stays set until the next configuration write to that queue.
- R9: When a producer increment and a consumer increment reach the same queue in the same cycle, each is accepted or refused against the count from before that cycle. If both are accepted, the count does not change.
- R10: A select value of 31 or above addresses no queue. Its outputs read address 0, empty=1, full=0, not-empty=0 and no sticky flags, and increments sent with it change no queue.
- R11: An increment or configuration write changes only the queue it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Queue selected for configuration |
| cfg_is_tx | input | 1 | Direction: 1 = transmit, 0 = receive |
| cfg_base | input | 11 | Base byte address in message RAM |
| cfg_depth_m1 | input | 5 | Depth in slots minus one |
| host_sel | input | 5 | Queue selected by host |
| host_inc | input | 1 | Host finished one slot |
| host_addr | output | 11 | Next RAM address for host |
| host_full | output | 1 | Selected queue full |
| host_empty | output | 1 | Selected queue empty |
| host_not_empty | output | 1 | Selected queue holds a message |
| host_overflow | output | 1 | Sticky overflow of selected queue |
| host_underflow | output | 1 | Sticky underflow of selected queue |
| ctrl_sel | input | 5 | Queue selected by protocol engine |
| ctrl_inc | input | 1 | Protocol engine finished one slot |
| ctrl_addr | output | 11 | Next RAM address for protocol engine |
| ctrl_full | output | 1 | Selected queue full |
| ctrl_empty | output | 1 | Selected queue empty |
| ctrl_not_empty | output | 1 | Selected queue holds a message |

## Verification
The hardest case to reach is a queue that is full or empty at the exact cycle when a producer increment and a consumer increment hit it together. Random traffic spread over 31 queues seldom lines that up. The stimulus handles this in two ways. Directed sequences fill one small queue to its limit and then fire both sides at once. The random phase sends most selects to four queues, gives them small depths and adds rare reconfigurations, so those queues keep swinging between full and empty while the other queues stay unused. Address wrap past the top of RAM is reached directly with a base near the end of the 2 KB space.

// File: rtl/msg_fifo_pkg.sv
package msg_fifo_pkg;

    localparam int NUM_FIFO  = 31;
    localparam int RAM_BYTES = 2048;
    localparam int OBJ_BYTES = 16;
    localparam int MAX_DEPTH = 32;

    localparam int SEL_W     = $clog2(NUM_FIFO + 1);
    localparam int ADDR_W    = $clog2(RAM_BYTES);
    localparam int IDX_W     = $clog2(MAX_DEPTH);
    localparam int CNT_W     = IDX_W + 1;
    localparam int OBJ_SHIFT = $clog2(OBJ_BYTES);

    typedef struct packed {
        logic              is_tx;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  depth_m1;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t         cfg;
        logic [IDX_W-1:0]  wr_idx;
        logic [IDX_W-1:0]  rd_idx;
        logic [CNT_W-1:0]  count;
        logic              ovf;
        logic              unf;
    } chan_state_t;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] idx,
                                                  input logic [IDX_W-1:0] last);
        return (idx == last) ? '0 : idx + IDX_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] depth_of(input logic [IDX_W-1:0] depth_m1);
        return CNT_W'(depth_m1) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/msg_fifo_chan.sv
module msg_fifo_chan
    import msg_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_hit,
    input  chan_cfg_t   cfg_in,
    input  logic        host_hit,
    input  logic        ctrl_hit,
    output chan_state_t st
);

    chan_state_t s_d, s_q;
    logic prod, cons, is_full, is_empty, prod_ok, cons_ok;

    always_comb begin
        s_d      = s_q;
        prod     = s_q.cfg.is_tx ? host_hit : ctrl_hit;
        cons     = s_q.cfg.is_tx ? ctrl_hit : host_hit;
        is_full  = (s_q.count == depth_of(s_q.cfg.depth_m1));
        is_empty = (s_q.count == '0);
        prod_ok  = prod && !is_full;
        cons_ok  = cons && !is_empty;
        if (cfg_hit) begin
            s_d.cfg    = cfg_in;
            s_d.wr_idx = '0;
            s_d.rd_idx = '0;
            s_d.count  = '0;
            s_d.ovf    = 1'b0;
            s_d.unf    = 1'b0;
        end else begin
            if (prod && is_full)  s_d.ovf = 1'b1;
            if (cons && is_empty) s_d.unf = 1'b1;
            if (prod_ok) s_d.wr_idx = step_idx(s_q.wr_idx, s_q.cfg.depth_m1);
            if (cons_ok) s_d.rd_idx = step_idx(s_q.rd_idx, s_q.cfg.depth_m1);
            s_d.count = s_q.count + CNT_W'(prod_ok) - CNT_W'(cons_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st = s_q;

    // R6: occupancy never exceeds the configured depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= depth_of(s_q.cfg.depth_m1));

    // R5: indices stay inside the slot range
    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wr_idx <= s_q.cfg.depth_m1) && (s_q.rd_idx <= s_q.cfg.depth_m1));

    // R7: a refused producer step leaves the write index and raises overflow
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod && is_full && !cfg_hit) |=> ($stable(s_q.wr_idx) && s_q.ovf));

    // R8: a refused consumer step leaves the read index and raises underflow
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cons && is_empty && !cfg_hit) |=> ($stable(s_q.rd_idx) && s_q.unf));

    // R7: overflow is sticky until reconfiguration
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !cfg_hit) |=> s_q.ovf);

    // R2: configuration leaves the queue cleared
    assert_cfg_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (s_q.count == '0 && s_q.wr_idx == '0 && s_q.rd_idx == '0
                     && !s_q.ovf && !s_q.unf));

endmodule

// File: rtl/msg_fifo_view.sv
module msg_fifo_view
    import msg_fifo_pkg::*;
#(
    parameter bit HOST_SIDE = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  chan_state_t [NUM_FIFO-1:0] states,
    input  logic [SEL_W-1:0]           sel,
    output logic [ADDR_W-1:0]          addr,
    output logic                       full,
    output logic                       empty,
    output logic                       not_empty,
    output logic                       ovf,
    output logic                       unf
);

    chan_state_t      pick;
    logic             valid;
    logic [IDX_W-1:0] idx;

    always_comb begin
        pick  = '0;
        valid = 1'b0;
        for (int i = 0; i < NUM_FIFO; i++) begin
            if (sel == SEL_W'(i)) begin
                pick  = states[i];
                valid = 1'b1;
            end
        end
        // producer side of this port follows the write index
        idx       = (pick.cfg.is_tx == HOST_SIDE) ? pick.wr_idx : pick.rd_idx;
        addr      = pick.cfg.base + (ADDR_W'(idx) << OBJ_SHIFT);
        full      = valid && (pick.count == depth_of(pick.cfg.depth_m1));
        empty     = (pick.count == '0);
        not_empty = !empty;
        ovf       = pick.ovf;
        unf       = pick.unf;
    end

    // R6: a queue is never reported full and empty together
    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/msg_fifo_ctrl.sv
module msg_fifo_ctrl
    import msg_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_is_tx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_depth_m1,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_inc,
    output logic [ADDR_W-1:0] host_addr,
    output logic              host_full,
    output logic              host_empty,
    output logic              host_not_empty,
    output logic              host_overflow,
    output logic              host_underflow,
    input  logic [SEL_W-1:0]  ctrl_sel,
    input  logic              ctrl_inc,
    output logic [ADDR_W-1:0] ctrl_addr,
    output logic              ctrl_full,
    output logic              ctrl_empty,
    output logic              ctrl_not_empty
);

    chan_state_t [NUM_FIFO-1:0] states;
    chan_cfg_t                  cfg_word;
    logic                       ctrl_ovf_nc, ctrl_unf_nc;

    assign cfg_word = '{is_tx: cfg_is_tx, base: cfg_base, depth_m1: cfg_depth_m1};

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_chan
        msg_fifo_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hit  (cfg_we   && cfg_sel  == SEL_W'(g)),
            .cfg_in   (cfg_word),
            .host_hit (host_inc && host_sel == SEL_W'(g)),
            .ctrl_hit (ctrl_inc && ctrl_sel == SEL_W'(g)),
            .st       (states[g])
        );
    end

    msg_fifo_view #(.HOST_SIDE(1'b1)) u_host_view (
        .clk(clk), .rst_n(rst_n), .states(states), .sel(host_sel),
        .addr(host_addr), .full(host_full), .empty(host_empty),
        .not_empty(host_not_empty), .ovf(host_overflow), .unf(host_underflow)
    );

    msg_fifo_view #(.HOST_SIDE(1'b0)) u_ctrl_view (
        .clk(clk), .rst_n(rst_n), .states(states), .sel(ctrl_sel),
        .addr(ctrl_addr), .full(ctrl_full), .empty(ctrl_empty),
        .not_empty(ctrl_not_empty), .ovf(ctrl_ovf_nc), .unf(ctrl_unf_nc)
    );

    // R10: an unused select shows an idle, empty queue on the host side
    assert_bad_sel_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(host_sel) >= NUM_FIFO) |-> (host_empty && !host_overflow && host_addr == '0));

endmodule

// File: tb/msg_fifo_ctrl_test.sv
`timescale 1ns/1ps
module msg_fifo_ctrl_test;

    localparam int NF = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_is_tx = 0, host_inc = 0, ctrl_inc = 0;
    logic [4:0]  cfg_sel = 0, cfg_depth_m1 = 0, host_sel = 0, ctrl_sel = 0;
    logic [10:0] cfg_base = 0;
    logic [10:0] host_addr, ctrl_addr;
    logic        host_full, host_empty, host_not_empty, host_overflow, host_underflow;
    logic        ctrl_full, ctrl_empty, ctrl_not_empty;

    int checks = 0, errors = 0;
    int m_tx [NF], m_base [NF], m_dm1 [NF], m_wr [NF], m_rd [NF], m_cnt [NF];
    int m_ovf [NF], m_unf [NF];

    always #2.5 clk = ~clk;

    msg_fifo_ctrl uut (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NF; i++) begin
            m_tx[i] = 0; m_base[i] = 0; m_dm1[i] = 0; m_wr[i] = 0; m_rd[i] = 0;
            m_cnt[i] = 0; m_ovf[i] = 0; m_unf[i] = 0;
        end
    endtask

    task automatic model_update();
        for (int i = 0; i < NF; i++) begin
            bit hh, ch, prod, cons, pok, cok;
            hh = host_inc && host_sel == i;
            ch = ctrl_inc && ctrl_sel == i;
            if (cfg_we && cfg_sel == i) begin
                m_tx[i] = cfg_is_tx; m_base[i] = cfg_base; m_dm1[i] = cfg_depth_m1;
                m_wr[i] = 0; m_rd[i] = 0; m_cnt[i] = 0; m_ovf[i] = 0; m_unf[i] = 0;
            end else begin
                prod = m_tx[i] ? hh : ch;
                cons = m_tx[i] ? ch : hh;
                pok  = prod && m_cnt[i] != m_dm1[i] + 1;
                cok  = cons && m_cnt[i] != 0;
                if (prod && !pok) m_ovf[i] = 1;
                if (cons && !cok) m_unf[i] = 1;
                if (pok) m_wr[i] = (m_wr[i] == m_dm1[i]) ? 0 : m_wr[i] + 1;
                if (cok) m_rd[i] = (m_rd[i] == m_dm1[i]) ? 0 : m_rd[i] + 1;
                m_cnt[i] = m_cnt[i] + int'(pok) - int'(cok);
            end
        end
    endtask

    task automatic compare(input string tag);
        int h, c, idx;
        h = host_sel; c = ctrl_sel;
        if (h < NF) begin
            idx = m_tx[h] ? m_wr[h] : m_rd[h];
            chk(tag, "host_addr", host_addr, (m_base[h] + idx * 16) % 2048);
            chk(tag, "host_full", host_full, m_cnt[h] == m_dm1[h] + 1);
            chk(tag, "host_empty", host_empty, m_cnt[h] == 0);
            chk(tag, "host_not_empty", host_not_empty, m_cnt[h] != 0);
            chk(tag, "host_overflow", host_overflow, m_ovf[h]);
            chk(tag, "host_underflow", host_underflow, m_unf[h]);
        end else begin
            chk("R10", "host_addr", host_addr, 0);
            chk("R10", "host_flags", {host_full, host_empty, host_not_empty,
                                      host_overflow, host_underflow}, 5'b01000);
        end
        if (c < NF) begin
            idx = m_tx[c] ? m_rd[c] : m_wr[c];
            chk(tag, "ctrl_addr", ctrl_addr, (m_base[c] + idx * 16) % 2048);
            chk(tag, "ctrl_full", ctrl_full, m_cnt[c] == m_dm1[c] + 1);
            chk(tag, "ctrl_empty", ctrl_empty, m_cnt[c] == 0);
            chk(tag, "ctrl_not_empty", ctrl_not_empty, m_cnt[c] != 0);
        end else begin
            chk("R10", "ctrl_flags", {ctrl_addr, ctrl_full, ctrl_empty, ctrl_not_empty}, 3'b010);
        end
    endtask

    // inputs are set at the falling edge before calling step
    task automatic step(input string tag);
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        compare(tag);
        cfg_we = 0; host_inc = 0; ctrl_inc = 0;
    endtask

    task automatic configure(input int q, input bit tx, input int base, input int dm1);
        cfg_we = 1; cfg_sel = 5'(q); cfg_is_tx = tx; cfg_base = 11'(base); cfg_depth_m1 = 5'(dm1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: every queue after reset
        for (int i = 0; i < 32; i++) begin
            host_sel = 5'(i); ctrl_sel = 5'(i);
            #1;
            compare("R1");
        end
        @(negedge clk);

        // R2 / R3: transmit queue 3, base 0x100, four slots
        configure(3, 1, 'h100, 3); host_sel = 3; ctrl_sel = 3;
        step("R2");
        for (int k = 0; k < 4; k++) begin host_inc = 1; step("R3"); end
        chk("R5", "host_addr_wrapped", host_addr, 'h100);
        chk("R6", "full_after_four", host_full, 1);
        host_inc = 1; step("R7");
        chk("R7", "overflow_set", host_overflow, 1);
        host_inc = 1; ctrl_inc = 1; step("R9");
        chk("R9", "count_after_race", ctrl_full, 0);
        for (int k = 0; k < 3; k++) begin ctrl_inc = 1; step("R3"); end
        chk("R6", "empty_after_drain", ctrl_empty, 1);
        host_inc = 1; ctrl_inc = 1; step("R9");
        chk("R9", "push_ok_pop_refused", host_not_empty, 1);
        ctrl_inc = 1; step("R3");
        ctrl_inc = 1; step("R8");
        chk("R8", "underflow_set", host_underflow, 1);
        chk("R7", "overflow_still_set", host_overflow, 1);

        // R4 / R5: receive queue 7 near the top of RAM
        configure(7, 0, 'h7F0, 2); host_sel = 7; ctrl_sel = 7;
        step("R2");
        ctrl_inc = 1; step("R4");
        chk("R5", "ctrl_addr_ram_wrap", ctrl_addr, 0);
        chk("R4", "host_addr_read_slot", host_addr, 'h7F0);
        host_inc = 1; step("R4");
        host_inc = 1; step("R8");

        // R10: unused select leaves queues alone
        host_sel = 31; ctrl_sel = 31; host_inc = 1; ctrl_inc = 1; step("R10");
        host_sel = 3; ctrl_sel = 7; step("R11");

        // R2: configuration beats an increment in the same cycle
        configure(3, 1, 'h200, 1); host_sel = 3; host_inc = 1; step("R2");
        chk("R2", "cfg_wins_empty", host_empty, 1);
        chk("R2", "cfg_clears_sticky", host_overflow, 0);

        // R11: random traffic focused on a few queues
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 19) == 0)
                configure($urandom_range(0, 31), 1'($urandom), $urandom, $urandom_range(0, 5));
            host_sel = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'($urandom_range(0, 3));
            ctrl_sel = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'($urandom_range(0, 3));
            host_inc = 1'($urandom);
            ctrl_inc = 1'($urandom);
            step("R11");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule